// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the status byte of an 8-bit processor core. Every cycle in which the ALU retires an operation, it derives carry, nibble carry, zero and signed overflow from the operands and result the ALU presents. A per-flag mask chooses which of these flags the instruction may change. The operation class limits which flags it can touch at all: add and subtract touch all four, logic touches only zero, and rotate-through-carry touches only carry. Subtraction follows the inverted-borrow convention, so the carry flags read 1 when no borrow occurs.

Two further bits keep a history of power and watchdog events. One bit records that the core entered halt. The other records that the watchdog expired. Both are driven only by event strobes from the core and the watchdog, never by software writes. Software can load the four arithmetic flags through a write port, and the whole byte is always visible on the read port. The two top bits read as zero.

Top module: `cpu_flag_reg`

## Requirements
- R1: Driving rst_n low at a rising clock edge clears all eight status bits, so rd_data reads 0x00 after that edge.
- R2: On an add (alu_op=0), the flags with a set mask bit are loaded as follows. Bit 0 takes the carry out of the operand sum. Bit 1 takes the carry out of the low 4 bits. Bit 3 takes the carry into the top bit XOR the carry out of it.
- R3: A subtract (alu_op=1) is evaluated as a + ~b + 1. Bit 0 becomes 1 when a >= b unsigned, bit 1 becomes 1 when a[3:0] >= b[3:0], and bit 3 reports signed overflow of a - b.
- R4: For add, subtract and logic operations with mask bit 2 set, bit 2 becomes 1 exactly when alu_res is zero.
- R5: A logic operation (alu_op=2) never changes bits 0, 1 and 3, whatever the mask.
- R6: A rotate-through-carry (alu_op=3) loads bit 0 from rot_bit when mask bit 0 is set and leaves bits 1 to 3 unchanged.
- R7: The mask bits map onto status bits: mask[0] is carry, mask[1] is nibble carry, mask[2] is zero and mask[3] is overflow. A flag whose mask bit is clear holds its value, and nothing changes while alu_valid is low.
- R8: When wr_en is high, bits 3:0 load wr_data[3:0] at the clock edge, taking precedence over any ALU update in that cycle. wr_data[7:4] has no effect, and bits 5:4 are not changed by the write.
- R9: Bit 4 (halted) is set by evt_halt and cleared by evt_wdt_clr. When both arrive in one cycle, the bit is set.
- R10: Bit 5 (watchdog expired) is set by evt_wdt_to and cleared by evt_wdt_clr or evt_halt. When evt_wdt_to coincides with either clearing event, the bit is set.
- R11: Bits 7:6 of rd_data always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| alu_valid | input | 1 | ALU presents a completed operation this cycle |
| alu_op | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| opnd_a | input | DATA_W | First ALU operand |
| opnd_b | input | DATA_W | Second ALU operand (subtrahend on subtract) |
| alu_res | input | DATA_W | ALU result, used for the zero flag |
| rot_bit | input | 1 | Bit shifted out by a rotate through carry |
| upd_mask | input | 4 | Per-flag update enables for bits 3:0 |
| evt_halt | input | 1 | Halt instruction executed |
| evt_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| evt_wdt_to | input | 1 | Watchdog timeout |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| rd_data | output | 8 | Current status byte |

## Verification
The bench builds the block with its default 8-bit datapath split at a 4-bit nibble. With those widths, the numeric edges of the flag logic can be driven directly: 0x7F+1 and 0x80-1 for signed overflow, 0xFF+1 for a full wrap that raises carry, nibble carry and zero together, and equal operands on subtract for the no-borrow case. The directed part sets the event strobes against each other in every conflicting pair, so the priority of the sticky bits is observed at the read port.

// File: rtl/flagreg_pkg.sv
// Package: shared operation classes and status bit positions for the
// status flag register. Assumes an 8-bit status byte.
package flagreg_pkg;
    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_ROT   = 2'd3
    } opc_t;

    localparam int STAT_W      = 8;
    localparam int ARITH_FLAGS = 4;
    localparam int BIT_C       = 0;
    localparam int BIT_AC      = 1;
    localparam int BIT_Z       = 2;
    localparam int BIT_OV      = 3;
    localparam int BIT_PD      = 4;
    localparam int BIT_TO      = 5;
endpackage

// File: rtl/flag_carry_chain.sv
// Ripple carry chain over two operands. It exposes the carry out, the
// carry out of the low nibble and the carry into the top bit.
// Assumes 0 < NIB_W < W.
module flag_carry_chain #(
    parameter int W     = 8,
    parameter int NIB_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         c_out,
    output logic         c_nib,
    output logic         c_msb_in
);
    logic [W:0] cy;

    assign cy[0] = cin;

    // One full-adder carry stage per operand bit
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    assign c_out    = cy[W];
    assign c_nib    = cy[NIB_W];
    assign c_msb_in = cy[W-1];
endmodule

// File: rtl/flag_arith_unit.sv
// Arithmetic flag group (carry, nibble carry, zero, overflow).
// It derives the candidate flags from the ALU operands. The operation
// class and the per-flag mask gate the update, and a software write
// overrides it. Assumes the ALU result is consistent with the operands.
module flag_arith_unit
    import flagreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alu_valid,
    input  opc_t                   op,
    input  logic [DATA_W-1:0]      a,
    input  logic [DATA_W-1:0]      b,
    input  logic [DATA_W-1:0]      res,
    input  logic                   rot_bit,
    input  logic [ARITH_FLAGS-1:0] mask,
    input  logic                   wr_en,
    input  logic [ARITH_FLAGS-1:0] wr_val,
    output logic [ARITH_FLAGS-1:0] flags_q
);
    logic                   is_sub;
    logic [DATA_W-1:0]      b_eff;
    logic                   c_out, c_nib, c_msb_in;
    logic                   res_zero;
    logic [ARITH_FLAGS-1:0] flags_d;

    assign is_sub   = (op == OPC_SUB);
    assign b_eff    = is_sub ? ~b : b;
    assign res_zero = (res == '0);

    flag_carry_chain #(.W(DATA_W), .NIB_W(NIB_W)) u_chain (
        .a        (a),
        .b        (b_eff),
        .cin      (is_sub),
        .c_out    (c_out),
        .c_nib    (c_nib),
        .c_msb_in (c_msb_in)
    );

    // Next flag value: hold, masked ALU update, or software write
    always_comb begin
        flags_d = flags_q;
        if (alu_valid) begin
            unique case (op)
                OPC_ADD, OPC_SUB: begin
                    if (mask[BIT_C])  flags_d[BIT_C]  = c_out;
                    if (mask[BIT_AC]) flags_d[BIT_AC] = c_nib;
                    if (mask[BIT_Z])  flags_d[BIT_Z]  = res_zero;
                    if (mask[BIT_OV]) flags_d[BIT_OV] = c_out ^ c_msb_in;
                end
                OPC_LOGIC: begin
                    if (mask[BIT_Z])  flags_d[BIT_Z]  = res_zero;
                end
                OPC_ROT: begin
                    if (mask[BIT_C])  flags_d[BIT_C]  = rot_bit;
                end
                default: flags_d = flags_q;
            endcase
        end
        if (wr_en) flags_d = wr_val;
    end

    // Flag storage with synchronous power-up clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/flag_sticky_unit.sv
// Power/watchdog history bits. The halted bit is set by halt and cleared
// by watchdog clear, with halt winning. The expired bit is set by timeout
// and cleared by halt or watchdog clear, with timeout winning.
// Assumes event strobes are single-cycle and synchronous to clk.
module flag_sticky_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_halt,
    input  logic evt_wdt_clr,
    input  logic evt_wdt_to,
    output logic pd_q,
    output logic to_q
);
    // Halted history bit
    always_ff @(posedge clk) begin
        if (!rst_n)           pd_q <= 1'b0;
        else if (evt_halt)    pd_q <= 1'b1;
        else if (evt_wdt_clr) pd_q <= 1'b0;
    end

    // Watchdog-expired history bit
    always_ff @(posedge clk) begin
        if (!rst_n)                       to_q <= 1'b0;
        else if (evt_wdt_to)              to_q <= 1'b1;
        else if (evt_halt || evt_wdt_clr) to_q <= 1'b0;
    end
endmodule

// File: rtl/cpu_flag_reg.sv
// Status flag register top. It combines the arithmetic flag group with
// the power/watchdog history bits into one status byte with zero-filled
// top bits. Assumes all inputs are synchronous to clk.
module cpu_flag_reg
    import flagreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [1:0]        alu_op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              rot_bit,
    input  logic [3:0]        upd_mask,
    input  logic              evt_halt,
    input  logic              evt_wdt_clr,
    input  logic              evt_wdt_to,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    localparam int PAD_W = STAT_W - BIT_TO - 1;

    logic [ARITH_FLAGS-1:0] arith_q;
    logic                   pd_q, to_q;

    flag_arith_unit #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_valid (alu_valid),
        .op        (opc_t'(alu_op)),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (alu_res),
        .rot_bit   (rot_bit),
        .mask      (upd_mask),
        .wr_en     (wr_en),
        .wr_val    (wr_data[ARITH_FLAGS-1:0]),
        .flags_q   (arith_q)
    );

    flag_sticky_unit u_sticky (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_halt    (evt_halt),
        .evt_wdt_clr (evt_wdt_clr),
        .evt_wdt_to  (evt_wdt_to),
        .pd_q        (pd_q),
        .to_q        (to_q)
    );

    // Status byte assembly; unused top bits are tied to zero
    always_comb begin
        rd_data = {{PAD_W{1'b0}}, to_q, pd_q, arith_q};
    end
endmodule

// File: rtl/flag_reg_chk.sv
// Checker for the status flag register. It observes only the top-level
// ports and is attached to every instance by the bind below.
module flag_reg_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_valid,
    input logic [1:0]        alu_op,
    input logic [DATA_W-1:0] alu_res,
    input logic [3:0]        upd_mask,
    input logic              evt_halt,
    input logic              evt_wdt_clr,
    input logic              evt_wdt_to,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == 8'h00);

    // R11
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);

    // R10
    to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wdt_to |=> rd_data[5]);

    // R9
    pd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_halt |=> rd_data[4]);

    // R9
    pd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt_clr && !evt_halt) |=> !rd_data[4]);

    // R8
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

    // R8
    wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !evt_halt && !evt_wdt_clr && !evt_wdt_to)
        |=> rd_data[5:4] == $past(rd_data[5:4]));

    // R5
    logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 2'd2 && !wr_en)
        |=> (rd_data[3] == $past(rd_data[3])) && (rd_data[1:0] == $past(rd_data[1:0])));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op != 2'd3 && upd_mask[2] && !wr_en)
        |=> rd_data[2] == ($past(alu_res) == '0));
endmodule

bind cpu_flag_reg flag_reg_chk #(.DATA_W(DATA_W)) u_flag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_valid   (alu_valid),
    .alu_op      (alu_op),
    .alu_res     (alu_res),
    .upd_mask    (upd_mask),
    .evt_halt    (evt_halt),
    .evt_wdt_clr (evt_wdt_clr),
    .evt_wdt_to  (evt_wdt_to),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data)
);

// File: tb/cpu_flag_reg_test.sv
// Bench for the status flag register: vector table, then directed tests.
module cpu_flag_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 17;

    // Vector fields: op(2) a(8) b(8) res(8) mask(4) rot(1) expected bits 3:0 (4)
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 8'h01, 8'h01, 8'h02, 4'hF, 1'b0, 4'b0000}, // R2 plain add
        {2'd0, 8'hFF, 8'h01, 8'h00, 4'hF, 1'b0, 4'b0111}, // R2 R4 full wrap
        {2'd0, 8'h7F, 8'h01, 8'h80, 4'hF, 1'b0, 4'b1010}, // R2 signed overflow
        {2'd0, 8'h80, 8'h80, 8'h00, 4'hF, 1'b0, 4'b1101}, // R2 negative overflow
        {2'd1, 8'h05, 8'h03, 8'h02, 4'hF, 1'b0, 4'b0011}, // R3 no borrow
        {2'd1, 8'h03, 8'h05, 8'hFE, 4'hF, 1'b0, 4'b0000}, // R3 borrow
        {2'd1, 8'h80, 8'h01, 8'h7F, 4'hF, 1'b0, 4'b1001}, // R3 overflow, nibble borrow
        {2'd2, 8'hF0, 8'h0F, 8'h00, 4'hF, 1'b0, 4'b1101}, // R5 zero result
        {2'd2, 8'hF0, 8'h5A, 8'h5A, 4'hF, 1'b0, 4'b1001}, // R5 nonzero result
        {2'd1, 8'h42, 8'h42, 8'h00, 4'hF, 1'b0, 4'b0111}, // R3 equal operands
        {2'd3, 8'h00, 8'h00, 8'h81, 4'hF, 1'b0, 4'b0110}, // R6 rotate in 0
        {2'd3, 8'h00, 8'h00, 8'h81, 4'hF, 1'b1, 4'b0111}, // R6 rotate in 1
        {2'd0, 8'h01, 8'h01, 8'h02, 4'h4, 1'b0, 4'b0011}, // R7 zero only
        {2'd0, 8'h7F, 8'h01, 8'h80, 4'h8, 1'b0, 4'b1011}, // R7 overflow only
        {2'd0, 8'h01, 8'h02, 8'h03, 4'h3, 1'b0, 4'b1000}, // R7 carries only
        {2'd2, 8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 4'b1000}, // R7 empty mask
        {2'd3, 8'h00, 8'h00, 8'h00, 4'hE, 1'b1, 4'b1000}  // R7 carry masked
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_valid = 1'b0;
    logic [1:0] alu_op = 2'd0;
    logic [7:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic       rot_bit = 1'b0;
    logic [3:0] upd_mask = '0;
    logic       evt_halt = 1'b0, evt_wdt_clr = 1'b0, evt_wdt_to = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res), .rot_bit(rot_bit),
        .upd_mask(upd_mask), .evt_halt(evt_halt), .evt_wdt_clr(evt_wdt_clr),
        .evt_wdt_to(evt_wdt_to), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock edge, then back to the falling edge for sampling
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        alu_valid = 1'b0; wr_en = 1'b0;
        evt_halt = 1'b0; evt_wdt_clr = 1'b0; evt_wdt_to = 1'b0;
    endtask

    task automatic events(input logic h, input logic c, input logic t);
        idle();
        evt_halt = h; evt_wdt_clr = c; evt_wdt_to = t;
        step();
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tag;
        step();
        step();
        check("R1 reset state", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            alu_valid = 1'b1;
            alu_op    = VEC[i][34:33];
            opnd_a    = VEC[i][32:25];
            opnd_b    = VEC[i][24:17];
            alu_res   = VEC[i][16:9];
            upd_mask  = VEC[i][8:5];
            rot_bit   = VEC[i][4];
            step();
            if (upd_mask != 4'hF)   tag = "R7 masked update";
            else if (alu_op == 2'd0) tag = "R2 R4 add flags";
            else if (alu_op == 2'd1) tag = "R3 R4 subtract flags";
            else if (alu_op == 2'd2) tag = "R5 R4 logic flags";
            else                     tag = "R6 rotate carry";
            check($sformatf("%s vec%0d", tag, i), rd_data, {4'h0, VEC[i][3:0]});
        end
        idle();

        // Directed: software write
        wr_en = 1'b1; wr_data = 8'hFF;
        step();
        idle();
        check("R8 R11 write upper bits ignored", rd_data, 8'h0F);

        wr_en = 1'b1; wr_data = 8'h05;
        alu_valid = 1'b1; alu_op = 2'd0; opnd_a = 8'hFF; opnd_b = 8'h01;
        alu_res = 8'h00; upd_mask = 4'hF;
        step();
        idle();
        check("R8 write beats ALU update", rd_data, 8'h05);

        // Directed: history bits
        events(1'b1, 1'b0, 1'b0);
        check("R9 halt sets halted bit", rd_data, 8'h15);
        events(1'b0, 1'b0, 1'b1);
        check("R10 timeout sets expired bit", rd_data, 8'h35);

        wr_en = 1'b1; wr_data = 8'h00;
        step();
        idle();
        check("R8 write leaves history bits", rd_data, 8'h30);

        events(1'b0, 1'b1, 1'b1);
        check("R9 R10 timeout beats clear", rd_data, 8'h20);
        events(1'b1, 1'b0, 1'b0);
        check("R10 halt clears expired bit", rd_data, 8'h10);
        events(1'b1, 1'b1, 1'b0);
        check("R9 halt beats clear", rd_data, 8'h10);
        events(1'b0, 1'b1, 1'b0);
        check("R9 clear drops halted bit", rd_data, 8'h00);
        events(1'b1, 1'b0, 1'b1);
        check("R10 timeout beats halt", rd_data, 8'h30);

        // Directed: no update without alu_valid
        alu_valid = 1'b0; alu_op = 2'd0; opnd_a = 8'hFF; opnd_b = 8'h01;
        alu_res = 8'h00; upd_mask = 4'hF;
        step();
        check("R7 idle ALU holds flags", rd_data, 8'h30);

        // Directed: reset in mid run
        wr_en = 1'b1; wr_data = 8'h0F;
        step();
        idle();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R1 reset clears all bits", rd_data, 8'h00);
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule